// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the four active-low control lines of an asynchronous DRAM interface: row strobe, column strobe, write enable and output enable. The lines are already synchronous to a fast sampling clock. The block works out what kind of memory cycle is under way from the order in which the lines change, not from the levels they hold at one instant. For each cycle it names the type, tells whether the column access is a later access within a page that is already open, and keeps the row address captured at the last row strobe fall. It also reports what the data pins should be doing at every moment: driven by the memory, receiving from the controller, or high-impedance.

The block can sit beside a memory controller as a protocol checker, or in front of a behavioural memory model, which then only has to act on the reported cycle type. It flags two timing rules, both measured in sample clocks: a row strobe that stays low too briefly, and a row precharge that is too short. It also flags a write enable that falls while the read data is still enabled onto the bus.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, cyc_valid is 0, cyc_type is 0 (standby) and bus_dir is 0 (high-impedance).
- R2: Whenever the row and column strobes are both sampled high, bus_dir returns to 0 (high-impedance) from the next clock edge on.
- R3: With write enable high, a read (cyc_type 1) is reported at the later of the column strobe fall and the output enable fall. bus_dir becomes 1 (driven). The read data stays driven through a column precharge in the same row, until the next column fall or until both strobes are high.
- R4: A write enable that is already low when the column strobe falls gives an early write (cyc_type 2). bus_dir is 2 (receiving) until the column strobe rises, whatever output enable does.
- R5: A write enable that falls after the column strobe, with output enable high and nothing read out yet, gives a late write (cyc_type 3) and bus_dir 2.
- R6: A write enable that falls after a read was reported in the same column cycle, with output enable high again, gives a read-modify-write (cyc_type 4) and bus_dir 2.
- R7: While output enable is sampled high, bus_dir is never 1. Raising output enable during a read makes the bus high-impedance.
- R8: A write enable fall during a read while output enable is still low raises viol_wr_oe for one clock. No cycle is reported and the bus stays driven.
- R9: A row strobe fall while the column strobe is low, with no access since both strobes were last high, gives a column-first refresh (cyc_type 6) and bus_dir 0.
- R10: A row strobe that rises with no column strobe fall since it fell gives a row-only refresh (cyc_type 5). It is reported at the rise.
- R11: A row strobe that rises and falls again while the column strobe stays low after a read or write gives a hidden refresh (cyc_type 7). Read data stays driven across it.
- R12: Every report carries row_tag, the address sampled at the last row fall with the column strobe high. page_col is 0 for the first column access of a row activation and 1 for later ones.
- R13: viol_act_short pulses for one clock at a row rise when the row strobe was sampled low on fewer than MIN_ACT clocks.
- R14: viol_pre_short pulses for one clock at a row fall when the row strobe was sampled high on fewer than MIN_PRE clocks since it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address lines |
| cyc_valid | output | 1 | One-clock pulse when a cycle type is decided |
| cyc_type | output | 4 | Cycle type code (see requirements) |
| page_col | output | 1 | Access is not the first column of its row activation |
| row_tag | output | ADDR_W | Row address captured at the last row fall |
| bus_dir | output | 2 | 0 high-impedance, 1 driven, 2 receiving |
| viol_act_short | output | 1 | Row strobe low period too short |
| viol_pre_short | output | 1 | Row precharge period too short |
| viol_wr_oe | output | 1 | Write enable fell while read data was enabled |

## Verification
A row strobe rise can end a row-only refresh and break the minimum active width in the same sample. The classifier and the timing counter then each report on the same clock. The bench provokes this by sweeping the low period of a bare row pulse from one to six clocks. At every rise it checks that the refresh report appears and that the width flag is set exactly when the period is below MIN_ACT. A second sweep varies the precharge ahead of a row fall and judges that flag arithmetically in the same way.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    localparam int NUM_LINES = 4;
    localparam int LN_OE     = 0;
    localparam int LN_WR     = 1;
    localparam int LN_COL    = 2;
    localparam int LN_ROW    = 3;

    typedef enum logic [3:0] {
        CYC_STANDBY   = 4'd0,
        CYC_READ      = 4'd1,
        CYC_EARLY_WR  = 4'd2,
        CYC_LATE_WR   = 4'd3,
        CYC_RMW       = 4'd4,
        CYC_ROW_RF    = 4'd5,
        CYC_COLROW_RF = 4'd6,
        CYC_HIDDEN_RF = 4'd7
    } cyc_e;

    typedef enum logic [1:0] {
        BUS_HIZ   = 2'd0,
        BUS_DRIVE = 2'd1,
        BUS_RECV  = 2'd2
    } bus_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_PEND,
        ST_READ,
        ST_WRITE,
        ST_RFSH
    } st_e;

endpackage

// File: rtl/dcd_edge_sense.sv
module dcd_edge_sense #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] smp,
    output logic [N-1:0] prev,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign fall[i] = prev_q[i] & ~smp[i];
        assign rise[i] = ~prev_q[i] & smp[i];
    end

    assign prev = prev_q;

endmodule

// File: rtl/dcd_row_timer.sv
module dcd_row_timer #(
    parameter int MIN_ACT = 4,
    parameter int MIN_PRE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_now,
    input  logic row_fall,
    input  logic row_rise,
    output logic viol_act,
    output logic viol_pre
);

    localparam int LIM = (MIN_ACT > MIN_PRE) ? MIN_ACT : MIN_PRE;
    localparam int CW  = $clog2(LIM + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(LIM);

    typedef struct packed {
        logic [CW-1:0] act;
        logic [CW-1:0] pre;
        logic          va;
        logic          vp;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        t_d.va = 1'b0;
        t_d.vp = 1'b0;
        if (row_fall) begin
            t_d.vp  = (t_q.pre < CW'(MIN_PRE));
            t_d.act = CW'(1);
        end else if (!row_now && t_q.act != SAT) begin
            t_d.act = t_q.act + CW'(1);
        end
        if (row_rise) begin
            t_d.va  = (t_q.act < CW'(MIN_ACT));
            t_d.pre = CW'(1);
        end else if (row_now && t_q.pre != SAT) begin
            t_d.pre = t_q.pre + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.act <= SAT;
            t_q.pre <= SAT;
            t_q.va  <= 1'b0;
            t_q.vp  <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign viol_act = t_q.va;
    assign viol_pre = t_q.vp;

endmodule

// File: rtl/dcd_cycle_fsm.sv
module dcd_cycle_fsm
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cur,
    input  logic [NUM_LINES-1:0] fall,
    input  logic [NUM_LINES-1:0] rise,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 valid,
    output cyc_e                 ctype,
    output logic                 page,
    output logic [ADDR_W-1:0]    row_tag,
    output bus_e                 bus,
    output logic                 viol_wo
);

    typedef struct packed {
        st_e               state;
        logic              hold;
        logic              rx;
        logic              acc;
        logic              col_seen;
        logic [ADDR_W-1:0] tag;
        logic              valid;
        cyc_e              ctype;
        logic              page;
        logic              viol;
        bus_e              bus;
    } fsm_t;

    fsm_t s_d, s_q;

    logic row_lo, col_lo, wr_lo, oe_lo;
    assign row_lo = ~cur[LN_ROW];
    assign col_lo = ~cur[LN_COL];
    assign wr_lo  = ~cur[LN_WR];
    assign oe_lo  = ~cur[LN_OE];

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.viol  = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (fall[LN_ROW]) begin
                    if (col_lo) begin
                        s_d.state = ST_RFSH;
                        s_d.valid = 1'b1;
                        s_d.page  = 1'b0;
                        if (s_q.acc) begin
                            s_d.ctype = CYC_HIDDEN_RF;
                        end else begin
                            s_d.ctype = CYC_COLROW_RF;
                            s_d.hold  = 1'b0;
                        end
                    end else begin
                        s_d.state    = ST_ROW;
                        s_d.tag      = addr;
                        s_d.col_seen = 1'b0;
                    end
                end
            end
            ST_ROW: begin
                if (rise[LN_ROW]) begin
                    s_d.state = ST_IDLE;
                    if (!s_q.col_seen) begin
                        s_d.valid = 1'b1;
                        s_d.ctype = CYC_ROW_RF;
                        s_d.page  = 1'b0;
                    end
                end else if (fall[LN_COL]) begin
                    s_d.page     = s_q.col_seen;
                    s_d.col_seen = 1'b1;
                    s_d.hold     = 1'b0;
                    if (wr_lo) begin
                        s_d.state = ST_WRITE;
                        s_d.valid = 1'b1;
                        s_d.ctype = CYC_EARLY_WR;
                        s_d.rx    = 1'b1;
                        s_d.acc   = 1'b1;
                    end else if (oe_lo) begin
                        s_d.state = ST_READ;
                        s_d.valid = 1'b1;
                        s_d.ctype = CYC_READ;
                        s_d.hold  = 1'b1;
                        s_d.acc   = 1'b1;
                    end else begin
                        s_d.state = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (fall[LN_WR]) begin
                    s_d.state = ST_WRITE;
                    s_d.valid = 1'b1;
                    s_d.ctype = CYC_LATE_WR;
                    s_d.rx    = 1'b1;
                    s_d.acc   = 1'b1;
                end else if (fall[LN_OE]) begin
                    s_d.state = ST_READ;
                    s_d.valid = 1'b1;
                    s_d.ctype = CYC_READ;
                    s_d.hold  = 1'b1;
                    s_d.acc   = 1'b1;
                end else if (rise[LN_ROW]) begin
                    s_d.state = ST_IDLE;
                end else if (rise[LN_COL]) begin
                    s_d.state = ST_ROW;
                end
            end
            ST_READ: begin
                if (fall[LN_WR]) begin
                    if (oe_lo) begin
                        s_d.viol = 1'b1;
                    end else begin
                        s_d.state = ST_WRITE;
                        s_d.valid = 1'b1;
                        s_d.ctype = CYC_RMW;
                        s_d.hold  = 1'b0;
                        s_d.rx    = 1'b1;
                    end
                end else if (rise[LN_ROW]) begin
                    s_d.state = ST_IDLE;
                end else if (rise[LN_COL]) begin
                    s_d.state = ST_ROW;
                end
            end
            ST_WRITE: begin
                if (rise[LN_ROW]) begin
                    s_d.state = ST_IDLE;
                    s_d.rx    = 1'b0;
                end else if (rise[LN_COL]) begin
                    s_d.state = ST_ROW;
                    s_d.rx    = 1'b0;
                end
            end
            ST_RFSH: begin
                if (rise[LN_ROW]) begin
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (!row_lo && !col_lo) begin
            s_d.hold = 1'b0;
            s_d.rx   = 1'b0;
            s_d.acc  = 1'b0;
        end

        if (s_d.rx)               s_d.bus = BUS_RECV;
        else if (s_d.hold && oe_lo) s_d.bus = BUS_DRIVE;
        else                      s_d.bus = BUS_HIZ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.hold     <= 1'b0;
            s_q.rx       <= 1'b0;
            s_q.acc      <= 1'b0;
            s_q.col_seen <= 1'b0;
            s_q.tag      <= '0;
            s_q.valid    <= 1'b0;
            s_q.ctype    <= CYC_STANDBY;
            s_q.page     <= 1'b0;
            s_q.viol     <= 1'b0;
            s_q.bus      <= BUS_HIZ;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid   = s_q.valid;
    assign ctype   = s_q.ctype;
    assign page    = s_q.page;
    assign row_tag = s_q.tag;
    assign bus     = s_q.bus;
    assign viol_wo = s_q.viol;

    // R4: a report of an early write always comes with the receive direction
    a_r4_early_write_receives: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && s_q.ctype == CYC_EARLY_WR) |-> s_q.bus == BUS_RECV);

    // R8: the write-under-read flag never coincides with a report
    a_r8_conflict_no_report: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.viol |-> (!s_q.valid && s_q.bus == BUS_DRIVE));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int MIN_ACT = 4,
    parameter int MIN_PRE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_valid,
    output logic [3:0]        cyc_type,
    output logic              page_col,
    output logic [ADDR_W-1:0] row_tag,
    output logic [1:0]        bus_dir,
    output logic              viol_act_short,
    output logic              viol_pre_short,
    output logic              viol_wr_oe
);

    logic [NUM_LINES-1:0] smp, prev, fall, rise;
    cyc_e ctype;
    bus_e bus;

    assign smp[LN_ROW] = row_stb_n;
    assign smp[LN_COL] = col_stb_n;
    assign smp[LN_WR]  = wr_en_n;
    assign smp[LN_OE]  = out_en_n;

    dcd_edge_sense #(.N(NUM_LINES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .smp  (smp),
        .prev (prev),
        .fall (fall),
        .rise (rise)
    );

    dcd_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (smp),
        .fall   (fall),
        .rise   (rise),
        .addr   (addr),
        .valid  (cyc_valid),
        .ctype  (ctype),
        .page   (page_col),
        .row_tag(row_tag),
        .bus    (bus),
        .viol_wo(viol_wr_oe)
    );

    dcd_row_timer #(.MIN_ACT(MIN_ACT), .MIN_PRE(MIN_PRE)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_now (row_stb_n),
        .row_fall(fall[LN_ROW]),
        .row_rise(rise[LN_ROW]),
        .viol_act(viol_act_short),
        .viol_pre(viol_pre_short)
    );

    assign cyc_type = ctype;
    assign bus_dir  = bus;

    // R2: both strobes high at the last sample means the bus is released
    a_r2_idle_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (prev[LN_ROW] && prev[LN_COL]) |-> bus_dir == BUS_HIZ);

    // R7: output enable high never leaves the memory driving
    a_r7_oe_high_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        prev[LN_OE] |-> bus_dir != BUS_DRIVE);

    // R9: a column-first refresh never has data on the bus
    a_r9_colrow_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == CYC_COLROW_RF) |-> bus_dir == BUS_HIZ);

    // R10: a row-only refresh is reported on a rising row strobe
    a_r10_row_rf_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type == CYC_ROW_RF) |-> (prev[LN_ROW] && !$past(prev[LN_ROW])));

    // R13: width flag only on the clock of a row rise
    a_r13_act_flag_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        viol_act_short |-> (prev[LN_ROW] && !$past(prev[LN_ROW])));

    // R14: precharge flag only on the clock of a row fall
    a_r14_pre_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pre_short |-> (!prev[LN_ROW] && $past(prev[LN_ROW])));

endmodule

// File: tb/dram_cycle_decoder_tb.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb;

    localparam int AW    = 4;
    localparam int MACT  = 4;
    localparam int MPRE  = 3;
    localparam int T_RD  = 1, T_EW = 2, T_LW = 3, T_RMW = 4;
    localparam int T_ROW = 5, T_CR = 6, T_HID = 7;
    localparam int B_Z   = 0, B_DRV = 1, B_RX = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic cyc_valid, page_col, v_act, v_pre, v_wo;
    logic [3:0] cyc_type;
    logic [AW-1:0] row_tag;
    logic [1:0] bus_dir;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_cycle_decoder #(.ADDR_W(AW), .MIN_ACT(MACT), .MIN_PRE(MPRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_n), .col_stb_n(col_n),
        .wr_en_n(wr_n), .out_en_n(oe_n), .addr(addr),
        .cyc_valid(cyc_valid), .cyc_type(cyc_type), .page_col(page_col),
        .row_tag(row_tag), .bus_dir(bus_dir), .viol_act_short(v_act),
        .viol_pre_short(v_pre), .viol_wr_oe(v_wo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o,
                       input logic [AW-1:0] a);
        @(negedge clk);
        row_n = r; col_n = c; wr_n = w; oe_n = o; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1, 1, 1, 1, '0);
    endtask

    task automatic rep(input string tag, input int typ);
        chk({tag, " valid"}, int'(cyc_valid), 1);
        chk({tag, " type"}, int'(cyc_type), typ);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 valid", int'(cyc_valid), 0);
        chk("R1 type", int'(cyc_type), 0);
        chk("R1 bus", int'(bus_dir), B_Z);
        @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        chk("R2 idle bus", int'(bus_dir), B_Z);

        // R3 column first, then output enable
        drv(0, 1, 1, 1, 4'd5); drv(0, 1, 1, 1, 4'd5);
        drv(0, 0, 1, 1, 4'd5);
        chk("R3 no report before oe", int'(cyc_valid), 0);
        drv(0, 0, 1, 0, 4'd5);
        rep("R3 read", T_RD);
        chk("R3 bus driven", int'(bus_dir), B_DRV);
        chk("R12 first column", int'(page_col), 0);
        drv(0, 0, 1, 1, 4'd5);
        chk("R7 oe high releases", int'(bus_dir), B_Z);
        drv(0, 1, 1, 1, 4'd5); drv(1, 1, 1, 1, 4'd5);
        idle(4);

        // R3 output enable first, data held across column precharge
        drv(0, 1, 1, 0, 4'd2); drv(0, 1, 1, 0, 4'd2);
        drv(0, 0, 1, 0, 4'd2);
        rep("R3 read oe first", T_RD);
        drv(0, 0, 1, 0, 4'd2);
        drv(0, 1, 1, 0, 4'd2);
        chk("R3 held after column rise", int'(bus_dir), B_DRV);
        drv(1, 1, 1, 0, 4'd2);
        chk("R2 both high releases", int'(bus_dir), B_Z);
        idle(4);

        // R4 early write
        drv(0, 1, 0, 1, 4'd1); drv(0, 1, 0, 1, 4'd1);
        drv(0, 0, 0, 1, 4'd1);
        rep("R4 early write", T_EW);
        chk("R4 bus", int'(bus_dir), B_RX);
        drv(0, 0, 0, 0, 4'd1);
        chk("R4 oe low ignored", int'(bus_dir), B_RX);
        drv(0, 0, 1, 1, 4'd1);
        chk("R4 wr release ignored", int'(bus_dir), B_RX);
        drv(0, 1, 1, 1, 4'd1);
        chk("R4 column rise", int'(bus_dir), B_Z);
        drv(1, 1, 1, 1, 4'd1);
        idle(4);

        // R5 late write
        drv(0, 1, 1, 1, 4'd3); drv(0, 1, 1, 1, 4'd3);
        drv(0, 0, 1, 1, 4'd3);
        drv(0, 0, 0, 1, 4'd3);
        rep("R5 late write", T_LW);
        chk("R5 bus", int'(bus_dir), B_RX);
        drv(0, 1, 1, 1, 4'd3); drv(1, 1, 1, 1, 4'd3);
        idle(4);

        // R6 read-modify-write
        drv(0, 1, 1, 1, 4'd6); drv(0, 1, 1, 1, 4'd6);
        drv(0, 0, 1, 1, 4'd6);
        drv(0, 0, 1, 0, 4'd6);
        rep("R6 read part", T_RD);
        drv(0, 0, 1, 1, 4'd6);
        drv(0, 0, 0, 1, 4'd6);
        rep("R6 rmw", T_RMW);
        chk("R6 bus", int'(bus_dir), B_RX);
        drv(0, 1, 1, 1, 4'd6); drv(1, 1, 1, 1, 4'd6);
        idle(4);

        // R8 write enable falls while read data enabled
        drv(0, 1, 1, 1, 4'd7); drv(0, 1, 1, 1, 4'd7);
        drv(0, 0, 1, 0, 4'd7);
        rep("R8 read", T_RD);
        drv(0, 0, 0, 0, 4'd7);
        chk("R8 flag", int'(v_wo), 1);
        chk("R8 no report", int'(cyc_valid), 0);
        chk("R8 bus still driven", int'(bus_dir), B_DRV);
        drv(0, 0, 1, 0, 4'd7);
        chk("R8 flag one clock", int'(v_wo), 0);
        drv(0, 1, 1, 1, 4'd7); drv(1, 1, 1, 1, 4'd7);
        idle(4);

        // R9 column-first refresh
        drv(1, 0, 1, 1, 4'd0); drv(1, 0, 1, 1, 4'd0);
        drv(0, 0, 1, 1, 4'd0);
        rep("R9 refresh", T_CR);
        chk("R9 bus", int'(bus_dir), B_Z);
        drv(0, 0, 1, 1, 4'd0); drv(0, 0, 1, 1, 4'd0); drv(0, 0, 1, 1, 4'd0);
        drv(1, 0, 1, 1, 4'd0); drv(1, 1, 1, 1, 4'd0);
        idle(4);

        // R11 hidden refresh after a read
        drv(0, 1, 1, 1, 4'd8); drv(0, 1, 1, 1, 4'd8);
        drv(0, 0, 1, 0, 4'd8);
        rep("R11 read", T_RD);
        drv(0, 0, 1, 0, 4'd8); drv(0, 0, 1, 0, 4'd8);
        drv(1, 0, 1, 0, 4'd8);
        chk("R11 data kept at row rise", int'(bus_dir), B_DRV);
        drv(1, 0, 1, 0, 4'd8); drv(1, 0, 1, 0, 4'd8);
        drv(0, 0, 1, 0, 4'd8);
        rep("R11 hidden", T_HID);
        chk("R11 data kept", int'(bus_dir), B_DRV);
        drv(0, 0, 1, 0, 4'd8); drv(0, 0, 1, 0, 4'd8); drv(0, 0, 1, 0, 4'd8);
        drv(1, 0, 1, 0, 4'd8); drv(1, 1, 1, 0, 4'd8);
        chk("R2 end of hidden", int'(bus_dir), B_Z);
        idle(4);

        // R12 page-mode column tagging
        drv(0, 1, 1, 0, 4'd9); drv(0, 1, 1, 0, 4'd3);
        drv(0, 0, 1, 0, 4'd3);
        rep("R12 first", T_RD);
        chk("R12 first page flag", int'(page_col), 0);
        drv(0, 1, 1, 0, 4'd4);
        drv(0, 0, 1, 0, 4'd4);
        rep("R12 second", T_RD);
        chk("R12 second page flag", int'(page_col), 1);
        chk("R12 tag", int'(row_tag), 9);
        drv(0, 1, 1, 0, 4'd4);
        drv(1, 1, 1, 1, 4'd4);
        chk("R10 no row-only after page", int'(cyc_valid), 0);
        idle(4);

        // R10 and R12: row-only refresh over every row address
        for (int a = 0; a < (1 << AW); a++) begin
            drv(0, 1, 1, 1, AW'(a));
            for (int k = 0; k < MACT; k++) drv(0, 1, 1, 1, ~AW'(a));
            drv(1, 1, 1, 1, ~AW'(a));
            rep("R10 row-only", T_ROW);
            chk("R12 row tag", int'(row_tag), a);
            idle(MPRE);
        end

        // R13 active width sweep, coinciding with the R10 report
        for (int n = 1; n <= 6; n++) begin
            idle(MPRE + 1);
            for (int k = 0; k < n; k++) drv(0, 1, 1, 1, '0);
            drv(1, 1, 1, 1, '0);
            chk("R13 width flag", int'(v_act), (n < MACT) ? 1 : 0);
            rep("R10 with width sweep", T_ROW);
        end

        // R14 precharge sweep
        for (int n = 1; n <= 5; n++) begin
            idle(MPRE + 1);
            for (int k = 0; k < MACT + 1; k++) drv(0, 1, 1, 1, '0);
            for (int k = 0; k < n; k++) drv(1, 1, 1, 1, '0);
            drv(0, 1, 1, 1, '0);
            chk("R14 precharge flag", int'(v_pre), (n < MPRE) ? 1 : 0);
            for (int k = 0; k < MACT; k++) drv(0, 1, 1, 1, '0);
            drv(1, 1, 1, 1, '0);
        end

        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule